// File: doc/BRIEF.md
# Coalescing Store Write Buffer

This block holds pending processor stores until the memory side drains them. It is a small first-in first-out queue of address and data pairs. A store offered on the input stream either takes a new slot at the tail or, when its address is already queued, overwrites the data of that queued entry where it stands. Because of this, one address never occupies two slots. The oldest entry is always offered on an output stream to the memory arbiter, and that entry leaves the queue when the arbiter accepts it.

A separate lookup port lets the load path ask whether the buffer holds a newer copy of a word than the cache does. The lookup searches every held entry in parallel. Its data and a miss flag come back from a register one cycle later, and a mux uses the flag to choose between the buffer and the cache.

Back-pressure rules: a store transfers on a rising edge where `st_valid` and `st_ready` are both high. `st_ready` is high when the queue is not full, or when the offered address matches a held entry, or when the head is being drained in the same cycle. A store offered while `st_ready` is low is discarded, and the source must hold it and offer it again. The head entry transfers on an edge where `hd_valid` and `hd_ready` are both high. `hd_ready` has no effect while the queue is empty.

Top module: `swb_store_buffer`

## Requirements
- R1: During and after a synchronous reset (`rst` high), `empty`=1, `full`=0, `hd_valid`=0, `rd_miss`=1 and `rd_data`=0.
- R2: An accepted store to an address not held in the queue is appended at the tail. `empty` and `hd_valid` are updated by the edge that accepts it, so they change in the following cycle.
- R3: `hd_addr`/`hd_data` show the oldest held entry. Each head transfer removes exactly that entry, and entries leave in their order of arrival.
- R4: A lookup sampled with `rd_en` high at an edge drives, after that edge, `rd_miss`=0 and the held data when an entry matches `rd_addr`. Otherwise it drives `rd_miss`=1 and `rd_data`=0. The lookup sees the entries held before that edge, not a store accepted on the same edge. Both outputs hold their value until the next lookup.
- R5: An accepted store whose address matches a held entry replaces that entry's data. The occupancy and the entry's queue position do not change.
- R6: `full` becomes 1 after the edge that accepts the fourth distinct entry (DEPTH=4). It stays 1 until a head transfer occurs.
- R7: When the queue is full and no head transfer happens in the cycle, a store to an address that is not held sees `st_ready`=0 and has no effect.
- R8: A store and a head transfer on the same edge leave the occupancy unchanged. A store to the address of the head entry that is leaving on that edge is appended as a new entry, so it is not lost.
- R9: `hd_ready` while `empty`=1 has no effect. The queue stays empty.
- R10: A store that matches a held address is accepted (`st_ready`=1) even while `full`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store will be taken on this edge |
| st_addr | input | AW (32) | Store address |
| st_data | input | DW (32) | Store data |
| hd_valid | output | 1 | Head entry present |
| hd_ready | input | 1 | Memory side takes the head entry |
| hd_addr | output | AW (32) | Address of the oldest entry |
| hd_data | output | DW (32) | Data of the oldest entry |
| rd_en | input | 1 | Lookup request |
| rd_addr | input | AW (32) | Lookup address |
| rd_data | output | DW (32) | Lookup data, registered |
| rd_miss | output | 1 | Lookup found no entry, registered |
| empty | output | 1 | No entries held |
| full | output | 1 | All DEPTH slots held |

## Verification
Every result of this block is due one edge after its stimulus. Occupancy flags, head outputs and lookup outputs change on the edge that samples the store, drain or lookup. `st_ready` is the exception: it is combinational and is valid in the same cycle as the offered store. The bench therefore drives inputs on the falling edge and reads `st_ready` one time unit later, before the next rising edge. It reads every registered output one time unit after the rising edge that should have updated it.

// File: rtl/swb_pkg.sv
package swb_pkg;
  typedef enum logic [1:0] {
    SWB_OP_IDLE = 2'b00,
    SWB_OP_POP  = 2'b01,
    SWB_OP_PUSH = 2'b10,
    SWB_OP_BOTH = 2'b11
  } swb_op_e;
endpackage

// File: rtl/swb_match.sv
module swb_match #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic [AW-1:0]             key,
  input  logic [DEPTH-1:0][AW-1:0]  tags,
  input  logic [DEPTH-1:0]          vld,
  output logic [DEPTH-1:0]          hit,
  output logic                      any,
  output logic [PW-1:0]             idx
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit[i] = vld[i] && (tags[i] == key);
  end

  assign any = |hit;

  always_comb begin
    idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit[i]) idx = idx | PW'(i);
    end
  end
endmodule

// File: rtl/swb_queue_ctl.sv
module swb_queue_ctl
  import swb_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_new,
  input  logic          pop,
  output logic [PW-1:0] head_ptr,
  output logic [PW-1:0] tail_ptr,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  swb_op_e op;

  assign op    = swb_op_e'({push_new, pop});
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      head_ptr <= '0;
      tail_ptr <= '0;
      count    <= '0;
    end else begin
      case (op)
        SWB_OP_PUSH: begin
          tail_ptr <= tail_ptr + 1'b1;
          count    <= count + 1'b1;
        end
        SWB_OP_POP: begin
          head_ptr <= head_ptr + 1'b1;
          count    <= count - 1'b1;
        end
        SWB_OP_BOTH: begin
          tail_ptr <= tail_ptr + 1'b1;
          head_ptr <= head_ptr + 1'b1;
        end
        default: ;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    full && push_new |-> pop);  // R7
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    full && !pop |=> full);  // R6
  AST_POP_DEC: assert property (@(posedge clk) disable iff (rst)
    pop && !push_new |=> count == $past(count) - 1'b1);  // R3
  AST_EMPTY_FALLS: assert property (@(posedge clk) disable iff (rst)
    push_new |=> !empty);  // R2
  AST_BOTH_KEEPS: assert property (@(posedge clk) disable iff (rst)
    push_new && pop |=> $stable(count));  // R8
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    empty && !push_new |=> empty);  // R9
endmodule

// File: rtl/swb_lookup.sv
module swb_lookup #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rd_en,
  input  logic [AW-1:0]             rd_addr,
  input  logic [DEPTH-1:0][AW-1:0]  tags,
  input  logic [DEPTH-1:0][DW-1:0]  words,
  input  logic [DEPTH-1:0]          vld,
  output logic [DW-1:0]             rd_data,
  output logic                      rd_miss
);
  logic [DEPTH-1:0] hit;
  logic             any;
  logic [PW-1:0]    idx;

  swb_match #(.AW(AW), .DEPTH(DEPTH)) u_rd_match (
    .key(rd_addr), .tags(tags), .vld(vld),
    .hit(hit), .any(any), .idx(idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rd_miss <= 1'b1;
    end else if (rd_en) begin
      rd_data <= any ? words[idx] : '0;
      rd_miss <= !any;
    end
  end

  AST_LOOKUP_MISS: assert property (@(posedge clk) disable iff (rst)
    rd_en && !any |=> rd_miss);  // R4
  AST_LOOKUP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_miss) && $stable(rd_data));  // R4
endmodule

// File: rtl/swb_store_buffer.sv
module swb_store_buffer #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          hd_valid,
  input  logic          hd_ready,
  output logic [AW-1:0] hd_addr,
  output logic [DW-1:0] hd_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_miss,
  output logic          empty,
  output logic          full
);
  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][DW-1:0] data_q;
  logic [DEPTH-1:0]         slot_vld;
  logic [DEPTH-1:0]         leave_mask;
  logic [DEPTH-1:0]         wr_hit;
  logic                     wr_any;
  logic [PW-1:0]            wr_idx;
  logic [PW-1:0]            head_ptr;
  logic [PW-1:0]            tail_ptr;
  logic [CW-1:0]            count;
  logic                     pop;
  logic                     accept;
  logic                     push_new;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [PW-1:0] offset;
    assign offset        = PW'(i) - head_ptr;
    assign slot_vld[i]   = CW'(offset) < count;
    assign leave_mask[i] = pop && (head_ptr == PW'(i));
  end

  assign pop = hd_ready && !empty;

  // The entry leaving this edge must not absorb a new store.
  swb_match #(.AW(AW), .DEPTH(DEPTH)) u_wr_match (
    .key(st_addr), .tags(addr_q), .vld(slot_vld & ~leave_mask),
    .hit(wr_hit), .any(wr_any), .idx(wr_idx)
  );

  assign st_ready = !full || wr_any || pop;
  assign accept   = st_valid && st_ready;
  assign push_new = accept && !wr_any;

  swb_queue_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk(clk), .rst(rst), .push_new(push_new), .pop(pop),
    .head_ptr(head_ptr), .tail_ptr(tail_ptr), .count(count),
    .empty(empty), .full(full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (push_new) begin
      addr_q[tail_ptr] <= st_addr;
      data_q[tail_ptr] <= st_data;
    end else if (accept) begin
      data_q[wr_idx] <= st_data;
    end
  end

  swb_lookup #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_lookup (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .tags(addr_q), .words(data_q), .vld(slot_vld),
    .rd_data(rd_data), .rd_miss(rd_miss)
  );

  assign hd_valid = !empty;
  assign hd_addr  = addr_q[head_ptr];
  assign hd_data  = data_q[head_ptr];

  AST_UNIQUE_ADDR: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_hit));  // R5
  AST_MERGE_KEEPS_SLOTS: assert property (@(posedge clk) disable iff (rst)
    accept && wr_any && !pop |=> $stable(slot_vld));  // R5
  AST_MATCH_READY: assert property (@(posedge clk) disable iff (rst)
    st_valid && wr_any |-> st_ready);  // R10
  AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (rst)
    hd_valid && !pop |=> hd_valid && $stable(hd_addr));  // R3
endmodule

// File: tb/test_swb_store_buffer.sv
module test_swb_store_buffer;
  localparam time CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st_valid = 1'b0;
  logic        st_ready;
  logic [31:0] st_addr = '0;
  logic [31:0] st_data = '0;
  logic        hd_valid;
  logic        hd_ready = 1'b0;
  logic [31:0] hd_addr;
  logic [31:0] hd_data;
  logic        rd_en = 1'b0;
  logic [31:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic        rd_miss;
  logic        empty;
  logic        full;

  int checks = 0;
  int failures = 0;
  logic rdy;

  always #(CLK_P / 2) clk = ~clk;

  swb_store_buffer i_swb_store_buffer (
    .clk(clk), .rst(rst),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .hd_valid(hd_valid), .hd_ready(hd_ready), .hd_addr(hd_addr), .hd_data(hd_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_miss(rd_miss),
    .empty(empty), .full(full)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: drive on falling edge, read st_ready before the rising edge,
  // release inputs one unit after the rising edge.
  task automatic cyc(input logic sv, input logic [31:0] a, input logic [31:0] d,
                     input logic pop, input logic re, input logic [31:0] ra,
                     output logic ready);
    @(negedge clk);
    st_valid = sv; st_addr = a; st_data = d;
    hd_ready = pop; rd_en = re; rd_addr = ra;
    #1 ready = st_ready;
    @(posedge clk);
    #1;
    st_valid = 1'b0; hd_ready = 1'b0; rd_en = 1'b0;
  endtask

  task automatic store(input logic [31:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0, '0, rdy);
  endtask

  task automatic drain();
    cyc(1'b0, '0, '0, 1'b1, 1'b0, '0, rdy);
  endtask

  task automatic look(input logic [31:0] a);
    cyc(1'b0, '0, '0, 1'b0, 1'b1, a, rdy);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R1 empty", {31'b0, empty}, 32'd1);
    check("R1 full", {31'b0, full}, 32'd0);
    check("R1 hd_valid", {31'b0, hd_valid}, 32'd0);
    check("R1 rd_miss", {31'b0, rd_miss}, 32'd1);
    check("R1 rd_data", rd_data, 32'd0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_fill_full_drop();
    do_reset();
    store(32'h10, 32'hA1);
    check("R2 empty falls", {31'b0, empty}, 32'd0);
    check("R2 hd_addr", hd_addr, 32'h10);
    store(32'h20, 32'hA2);
    store(32'h30, 32'hA3);
    check("R6 not full at 3", {31'b0, full}, 32'd0);
    store(32'h40, 32'hA4);
    check("R6 full at 4", {31'b0, full}, 32'd1);
    store(32'h50, 32'hA5);
    check("R7 ready low", {31'b0, rdy}, 32'd0);
    check("R6 full holds", {31'b0, full}, 32'd1);
    check("R3 head data 0", hd_data, 32'hA1);
    drain();
    check("R6 full clears", {31'b0, full}, 32'd0);
    check("R3 head 1", hd_addr, 32'h20);
    drain();
    check("R3 head 2", hd_addr, 32'h30);
    drain();
    check("R3 head 3", hd_addr, 32'h40);
    check("R3 head data 3", hd_data, 32'hA4);
    drain();
    check("R7 dropped store absent", {31'b0, empty}, 32'd1);
  endtask

  task automatic t_coalesce();
    do_reset();
    store(32'h100, 32'h1);
    store(32'h200, 32'h2);
    store(32'h100, 32'h3);
    check("R5 head data merged", hd_data, 32'h3);
    check("R5 head addr kept", hd_addr, 32'h100);
    drain();
    check("R5 second entry", hd_addr, 32'h200);
    drain();
    check("R5 no duplicate", {31'b0, empty}, 32'd1);
    store(32'h11, 32'h0);
    store(32'h22, 32'h0);
    store(32'h33, 32'h0);
    store(32'h44, 32'h0);
    store(32'h22, 32'hBEEF);
    check("R10 merge while full ready", {31'b0, rdy}, 32'd1);
    check("R10 still full", {31'b0, full}, 32'd1);
    look(32'h22);
    check("R5 merged data seen", rd_data, 32'hBEEF);
  endtask

  task automatic t_lookup();
    do_reset();
    store(32'h300, 32'hCAFE);
    look(32'h300);
    check("R4 hit data", rd_data, 32'hCAFE);
    check("R4 hit miss flag", {31'b0, rd_miss}, 32'd0);
    look(32'h400);
    check("R4 miss flag", {31'b0, rd_miss}, 32'd1);
    check("R4 miss data", rd_data, 32'd0);
    cyc(1'b1, 32'h500, 32'h55, 1'b0, 1'b1, 32'h500, rdy);
    check("R4 same-edge store not seen", {31'b0, rd_miss}, 32'd1);
    cyc(1'b0, '0, '0, 1'b0, 1'b0, '0, rdy);
    check("R4 output held", {31'b0, rd_miss}, 32'd1);
    look(32'h500);
    check("R4 later lookup hits", rd_data, 32'h55);
  endtask

  task automatic t_push_pop();
    do_reset();
    store(32'h60, 32'h6);
    store(32'h61, 32'h7);
    cyc(1'b1, 32'h62, 32'h8, 1'b1, 1'b0, '0, rdy);
    check("R8 head advanced", hd_addr, 32'h61);
    drain();
    check("R8 new entry queued", hd_addr, 32'h62);
    drain();
    check("R8 count kept", {31'b0, empty}, 32'd1);
    store(32'h70, 32'hD1);
    cyc(1'b1, 32'h70, 32'hD2, 1'b1, 1'b0, '0, rdy);
    check("R8 store to leaving head kept", {31'b0, hd_valid}, 32'd1);
    check("R8 re-queued addr", hd_addr, 32'h70);
    check("R8 re-queued data", hd_data, 32'hD2);
    drain();
    check("R8 single entry", {31'b0, empty}, 32'd1);
  endtask

  task automatic t_pop_empty();
    do_reset();
    drain();
    check("R9 stays empty", {31'b0, empty}, 32'd1);
    check("R9 no head", {31'b0, hd_valid}, 32'd0);
    store(32'h80, 32'h88);
    check("R9 head after store", hd_addr, 32'h80);
    check("R9 not full", {31'b0, full}, 32'd0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_fill_full_drop();
    t_coalesce();
    t_lookup();
    t_push_pop();
    t_pop_empty();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule